// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a bus-attached parallel I/O unit with 24 pins, arranged as three 8-bit ports: port 0, port 1 and port 2. Port 2 is split into two 4-bit halves. The pins form two groups of 12. The first group is port 1 plus the low half of port 2. The second group is port 0 plus the high half of port 2. Software reaches the block through a small register interface: a 3-bit address, write data, read data, a write strobe and a read strobe.

A single command register controls the block. When its top bit is set, the written word sets the direction of each port (or half-port) and the mode of each group. When its top bit is clear, the word sets or clears one bit of the port 2 output latch. Only the basic mode is fully implemented. The handshaked and strobed bidirectional mode codes are stored and read back, but the ports then behave exactly as in basic mode.

Pad tristate drivers are outside the block. It drives a latched output value and a per-pin output enable for every pin. Input pins pass through a synchronizer before they reach the read path.

Top module: `pio24_unit`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all 0), every output latch is 0 (`pin_out` all 0), and a read of the command register returns 8'h9B.
- R2: Register addresses are 0 for port 0, 2 for port 1, 4 for port 2 and 6 for the command register. A write to an odd address changes no state, and a read of an odd address returns 0.
- R3: A command write with bit 7 = 1 is a configuration word. In it, bit 4 sets port 0, bit 1 sets port 1, bit 3 sets the high half of port 2 and bit 0 sets the low half of port 2; a 1 means input and a 0 means output. `pin_oe` is 1 on every output pin and 0 on every input pin, and it changes only after a configuration write.
- R4: Bit 2 (group 1 mode) and bits 6:5 (group 2 mode) are stored and read back through the command register, but have no effect on pin behaviour. 8'h80 makes every port an output, and 8'h9F makes every port an input.
- R5: Every configuration write clears all 24 output latches.
- R6: A command write with bit 7 = 0 writes bit 0 of the data into port 2 latch bit number bits 3:1. Bits 6:4 are ignored, and the stored configuration is unchanged.
- R7: A write to a port address loads that port's output latch. This happens even when the port is an input. `pin_out` always shows the latches: port 0 on bits 7:0, port 1 on bits 15:8 and port 2 on bits 23:16.
- R8: A port read returns the output latch for output pins and the synchronized pin value for input pins. The two halves of port 2 are chosen separately.
- R9: Input pins pass through a two-flop synchronizer. A pin change driven before clock edge k becomes visible to a read sampled at edge k+2.
- R10: `rdata` loads on the clock edge where `rd_en` is high, using the state before that edge. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Pad input values |
| pin_out | output | 24 | Output latch values |
| pin_oe | output | 24 | Per-pin output enable |

## Verification
The bench uses a mixed port 2 setting, with one half as input and one as output. This exposes a design that ties the two halves together: such a design returns pin data where latch data is expected, or the reverse. Single-bit commands with junk in bits 6:4 catch a decoder that takes the wrong index field or lets a bit command overwrite the configuration. The bench reads the same pin change back to back to pin down synchronizer depth; one flop too few or too many shifts when the new value appears. Writes to odd addresses, and data writes to input ports, check that state changes only where intended. Configuration writes that follow latch writes catch a design that fails to clear the latches.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 3;
    localparam int PIN_W     = PORT_W * NUM_PORTS;
    localparam int NIB_W     = PORT_W / 2;
    localparam int ADDR_W    = 3;
    localparam int IDX_W     = $clog2(PORT_W);

    localparam logic [ADDR_W-1:0] ADR_P0  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_P1  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_P2  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CMD = 3'd6;

    // configuration word fields
    localparam int CFG_SEL_BIT  = 7;
    localparam int CFG_P2LO_BIT = 0;
    localparam int CFG_P1_BIT   = 1;
    localparam int CFG_P2HI_BIT = 3;
    localparam int CFG_P0_BIT   = 4;

    localparam logic [PORT_W-1:0] CFG_RESET = 8'h9B;

    typedef struct packed {
        logic [PORT_W-1:0] cfg;
        logic [PORT_W-1:0] lat2;
        logic [PORT_W-1:0] lat1;
        logic [PORT_W-1:0] lat0;
    } ctrl_state_t;

    function automatic logic [PIN_W-1:0] oe_of_cfg(input logic [PORT_W-1:0] c);
        return {{NIB_W{~c[CFG_P2HI_BIT]}}, {NIB_W{~c[CFG_P2LO_BIT]}},
                {PORT_W{~c[CFG_P1_BIT]}}, {PORT_W{~c[CFG_P0_BIT]}}};
    endfunction
endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output ctrl_state_t       st
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (addr)
                ADR_P0: st_d.lat0 = wdata;
                ADR_P1: st_d.lat1 = wdata;
                ADR_P2: st_d.lat2 = wdata;
                ADR_CMD: begin
                    if (wdata[CFG_SEL_BIT]) begin
                        st_d.cfg  = wdata;
                        st_d.lat0 = '0;
                        st_d.lat1 = '0;
                        st_d.lat2 = '0;
                    end else begin
                        st_d.lat2[wdata[IDX_W:1]] = wdata[0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg  <= CFG_RESET;
            st_q.lat0 <= '0;
            st_q.lat1 <= '0;
            st_q.lat2 <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    assert_cfg_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_CMD && wdata[CFG_SEL_BIT])
        |=> (st_q.lat0 == '0 && st_q.lat1 == '0 && st_q.lat2 == '0));

    assert_bit_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_CMD && !wdata[CFG_SEL_BIT])
        |=> (st_q.lat2[$past(wdata[IDX_W:1])] == $past(wdata[0]) && $stable(st_q.cfg)));

    assert_odd_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[0]) |=> $stable(st_q));
endmodule

// File: rtl/ppi_readmux.sv
module ppi_readmux
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_state_t       st,
    input  logic [PIN_W-1:0]  pins,
    output logic [PORT_W-1:0] rdata
);
    logic [PORT_W-1:0] rd_d, rd_q;
    logic [PORT_W-1:0] p0_v, p1_v, p2_v;

    always_comb begin
        p0_v = st.cfg[CFG_P0_BIT] ? pins[PORT_W-1:0]        : st.lat0;
        p1_v = st.cfg[CFG_P1_BIT] ? pins[2*PORT_W-1:PORT_W] : st.lat1;
        p2_v[NIB_W-1:0] = st.cfg[CFG_P2LO_BIT]
                        ? pins[2*PORT_W+NIB_W-1:2*PORT_W] : st.lat2[NIB_W-1:0];
        p2_v[PORT_W-1:NIB_W] = st.cfg[CFG_P2HI_BIT]
                        ? pins[PIN_W-1:2*PORT_W+NIB_W] : st.lat2[PORT_W-1:NIB_W];
        rd_d = rd_q;
        if (rd_en) begin
            unique case (addr)
                ADR_P0:  rd_d = p0_v;
                ADR_P1:  rd_d = p1_v;
                ADR_P2:  rd_d = p2_v;
                ADR_CMD: rd_d = st.cfg;
                default: rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/pio24_unit.sv
module pio24_unit
    import ppi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    ctrl_state_t      st;
    logic [PIN_W-1:0] pins_sync;

    ppi_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .st    (st)
    );

    ppi_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pins_sync)
    );

    ppi_readmux u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .addr  (addr),
        .st    (st),
        .pins  (pins_sync),
        .rdata (rdata)
    );

    assign pin_out = {st.lat2, st.lat1, st.lat0};
    assign pin_oe  = oe_of_cfg(st.cfg);

    assert_oe_only_on_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADR_CMD && wdata[CFG_SEL_BIT]) |=> $stable(pin_oe));

    assert_port0_oe_uniform_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[PORT_W-1:0] == '0) || (pin_oe[PORT_W-1:0] == '1));
endmodule

// File: tb/pio24_unit_test.sv
module pio24_unit_test;
    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] m_cfg;
    logic [7:0] m_lat [3];

    always #(CLK_NS/2) clk = ~clk;

    pio24_unit uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [23:0] exp_oe(input logic [7:0] c);
        return {{4{~c[3]}}, {4{~c[0]}}, {8{~c[1]}}, {8{~c[4]}}};
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cfg[4] ? pin_in[7:0]  : m_lat[0];
            3'd2: return m_cfg[1] ? pin_in[15:8] : m_lat[1];
            3'd4: return {m_cfg[3] ? pin_in[23:20] : m_lat[2][7:4],
                          m_cfg[0] ? pin_in[19:16] : m_lat[2][3:0]};
            3'd6: return m_cfg;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 3'd6) begin
            if (d[7]) begin
                m_cfg = d;
                m_lat[0] = '0; m_lat[1] = '0; m_lat[2] = '0;
            end else begin
                m_lat[2][d[3:1]] = d[0];
            end
        end else if (!a[0]) begin
            m_lat[a[2:1]] = d;
        end
    endtask

    // read issued at the current negedge, result sampled at the next one
    task automatic do_read(input logic [2:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic check_read(input string req, input logic [2:0] a);
        logic [7:0] e;
        logic [7:0] v;
        e = exp_read(a);
        do_read(a, v);
        check(req, {24'd0, v}, {24'd0, e});
    endtask

    task automatic check_pins(input string req);
        check(req, {8'd0, pin_out}, {8'd0, m_lat[2], m_lat[1], m_lat[0]});
        check(req, {8'd0, pin_oe}, {8'd0, exp_oe(m_cfg)});
    endtask

    task automatic set_pins(input logic [23:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        m_cfg = 8'h9B;
        m_lat[0] = '0; m_lat[1] = '0; m_lat[2] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_pins("R1 reset pins");
        check_read("R1 reset cmd", 3'd6);

        // R4 all-output word, R7 latches, R8 reads of outputs
        do_write(3'd6, 8'h80);
        do_write(3'd0, 8'h55);
        do_write(3'd2, 8'hC3);
        do_write(3'd4, 8'h5A);
        check_pins("R4 R7 all output");
        check_read("R8 port0 out", 3'd0);
        check_read("R8 port1 out", 3'd2);
        check_read("R8 port2 out", 3'd4);

        // R5 clear on config, R4 all-input word read back
        set_pins(24'h123456);
        do_write(3'd6, 8'h9F);
        check_pins("R5 R4 all input");
        check_read("R4 cmd readback", 3'd6);
        check_read("R8 port0 in", 3'd0);
        check_read("R8 port2 in", 3'd4);

        // R7 latch written while input
        do_write(3'd0, 8'h77);
        check_pins("R7 latch while input");
        check_read("R8 port0 still pins", 3'd0);

        // R3 R8 mixed port 2 halves
        do_write(3'd6, 8'h81);
        do_write(3'd4, 8'hA5);
        set_pins(24'h3C0000);
        check_pins("R3 mixed oe");
        check_read("R8 mixed port2", 3'd4);

        // R6 bit command with junk in 6:4
        do_write(3'd6, 8'h0F);
        check_pins("R6 set bit7");
        do_write(3'd6, 8'h7E);
        check_pins("R6 clear bit7 junk");
        do_write(3'd6, 8'h51);
        check_pins("R6 set bit0");
        check_read("R6 cfg unchanged", 3'd6);

        // R2 odd addresses
        do_write(3'd1, 8'hFF);
        do_write(3'd7, 8'h80);
        check_pins("R2 odd write ignored");
        check_read("R2 odd read", 3'd3);

        // R9 synchronizer depth, R10 read timing
        do_write(3'd6, 8'h9B);
        set_pins(24'h000011);
        pin_in = 24'h0000EE;
        do_read(3'd0, v); check("R9 edge1 old", {24'd0, v}, 32'h11);
        do_read(3'd0, v); check("R9 edge2 old", {24'd0, v}, 32'h11);
        do_read(3'd0, v); check("R9 edge3 new", {24'd0, v}, 32'hEE);
        repeat (4) @(negedge clk);
        check("R10 rdata held", {24'd0, rdata}, 32'hEE);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [2:0] a;
            logic [7:0] d;
            if ($urandom_range(0, 3) == 0) set_pins($urandom());
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom());
            if (a == 3'd6 && $urandom_range(0, 1) == 1) d[7] = 1'b1;
            do_write(a, d);
            check_pins("R3 R5 R6 R7 random pins");
            check_read("R8 R2 random read", 3'($urandom_range(0, 7)));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule